// File: doc/BRIEF.md
# Pointer-addressed two-wire register slave

This block is the bus side of a two-wire serial peripheral. It watches oversampled clock and data lines and recognises start and stop conditions. When a transfer carries its own 7-bit address, it acknowledges the address and gives the bus master access to a small bank of 16-bit registers. The bank sits outside the block and is reached through a plain parallel port with an address, a write strobe, write data and read data.

A write transfer always carries a pointer byte after the address. That byte picks the register. Any data bytes that follow arrive in pairs, high byte first, and each complete pair becomes one parallel write. The pointer is kept after the transfer ends, so later read transfers return the register it selects without sending it again. Read data leaves high byte first. The block only ever pulls the data line low, through an output-enable, and it has no clock output at all.

The two lowest address bits come from a four-way strap, so up to four of these slaves can share one bus.

Top module: `twi_ptr_slave`

## Requirements
- R1: The slave address is binary 10010 followed by the 2-bit strap code. Strap code 0 means tied to ground, 1 to supply, 2 to the data line and 3 to the clock line. The address byte carries this 7-bit address in bits 7..1 and the read/write flag in bit 0, where 1 means read. Only a matching address is acknowledged.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both are recognised at any point in a transfer. The SDA output-enable changes only while the synchronised SCL is low.
- R3: In a write transfer, the byte after the address byte is loaded as the pointer. `regAddr` shows its low PTR_W bits. The pointer is 0 after reset.
- R4: Write data bytes are taken as a high byte then a low byte. After the low byte's acknowledge clock, they produce exactly one single-cycle `regWrEn` pulse with `{high,low}` at `regAddr`. Further pairs write the same register again. A high byte with no low byte after it is never written.
- R5: A write transfer made of only the address and the pointer byte changes the pointer and causes no register write.
- R6: The slave pulls SDA low during the ninth clock of a matching address byte, of the pointer byte and of every write data byte.
- R7: After a non-matching address the slave drives nothing, loads no pointer and writes nothing until the next start or stop.
- R8: A read transfer returns the register selected by the most recently written pointer. The pointer persists across any number of read transfers.
- R9: A read sends the register's high byte and then its low byte, each most significant bit first. The word is captured when the address is acknowledged. If the master keeps acknowledging, the same high/low pair is sent again.
- R10: A master NACK on a read byte ends the transfer. The slave then leaves SDA released until the next start.
- R11: A repeated start ends the current transfer at once. An incomplete data pair is discarded, and the new address byte is decoded as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw serial clock line level |
| sdaIn | input | 1 | Raw serial data line level |
| strapSel | input | 2 | Strap code giving the two low address bits |
| sdaOe | output | 1 | 1 pulls the data line low |
| regAddr | output | PTR_W | Register index from the pointer |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 16 | Register write word |
| regRdData | input | 16 | Register read word at `regAddr` |

## Verification
The bench builds the block with PTR_W = 2 and SYNC_STAGES = 2, which gives a four-register bank. With that bank, every register can be written and read back, and pointer values above 3 show the truncation to the low bits. Every one of the 128 address values is tried with strap code 0, and the eight addresses around the slave's own are tried with each other strap code. This covers every match and mismatch of the strap decode. The bench also covers the ordering corner cases: pointer-only writes, lone high bytes, repeated starts in mid-write, NACK in mid-read and reads that run on past the low byte.

// File: rtl/twi_ptr_pkg.sv
package twi_ptr_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [4:0] ADDR_HI = 5'b10010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_PTR,
    S_RX_ACK,
    S_WDATA,
    S_TX,
    S_MACK,
    S_IGNORE
  } twiState_e;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic shiftIn;    // sample SDA into the receive shifter
    logic ptrLoad;    // receive shifter -> pointer
    logic msbLoad;    // receive shifter -> high-byte hold
    logic commit;     // issue the register write
    logic captureRd;  // latch read word, start driving its high byte
    logic txLoadMsb;  // reload high byte of held word
    logic txLoadLsb;  // load low byte of held word
    logic txShift;    // advance to next transmit bit
    logic drvAck;     // pull SDA low for acknowledge
    logic drvRelease; // release SDA
  } twiStrobe_t;

endpackage

// File: rtl/twi_ptr_datapath.sv
module twi_ptr_datapath
  import twi_ptr_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  twiStrobe_t        strb,
  input  logic [WORD_W-1:0] regRdData,
  output logic              startEvt,
  output logic              stopEvt,
  output logic              sclRise,
  output logic              sclFall,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [WORD_W-1:0] regWrData
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclQ, sdaQ;

  logic [BYTE_W-1:0] rxShift, msbHold, txShift;
  logic [WORD_W-1:0] rdHold;
  logic [PTR_W-1:0]  ptrReg;

  // Line synchronisers, idle-high after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS && !sclQ;
  assign sclFall  = !sclS && sclQ;
  assign startEvt = sclS && sclQ && sdaQ && !sdaS;
  assign stopEvt  = sclS && sclQ && !sdaQ && sdaS;
  assign sdaBit   = sdaS;
  assign rxByte   = rxShift;
  assign regAddr  = ptrReg;

  // Receive side: shifter, pointer, high-byte hold and write port.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      msbHold   <= '0;
      ptrReg    <= '0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (strb.ptrLoad) ptrReg  <= rxShift[PTR_W-1:0];
      if (strb.msbLoad) msbHold <= rxShift;
      if (strb.commit) begin
        regWrEn   <= 1'b1;
        regWrData <= {msbHold, rxShift};
      end
    end
  end

  // Transmit side and the open-drain enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHold  <= '0;
      txShift <= '0;
      sdaOe   <= 1'b0;
    end else if (strb.drvRelease) begin
      sdaOe <= 1'b0;
    end else if (strb.drvAck) begin
      sdaOe <= 1'b1;
    end else if (strb.captureRd) begin
      rdHold  <= regRdData;
      txShift <= regRdData[WORD_W-1:BYTE_W];
      sdaOe   <= ~regRdData[WORD_W-1];
    end else if (strb.txLoadMsb) begin
      txShift <= rdHold[WORD_W-1:BYTE_W];
      sdaOe   <= ~rdHold[WORD_W-1];
    end else if (strb.txLoadLsb) begin
      txShift <= rdHold[BYTE_W-1:0];
      sdaOe   <= ~rdHold[BYTE_W-1];
    end else if (strb.txShift) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
      sdaOe   <= ~txShift[BYTE_W-2];
    end
  end

  // The data line may only move while the clock is low.
  p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS || $past(startEvt || stopEvt));

  // A stop always leaves the line released.
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> !sdaOe);

  // Write strobe is a single-cycle pulse.
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // Pointer persists unless the control asks for a load.
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ptrLoad |=> $stable(ptrReg));

endmodule

// File: rtl/twi_ptr_control.sv
module twi_ptr_control
  import twi_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEvt,
  input  logic              stopEvt,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [1:0]        strapSel,
  output twiStrobe_t        strb
);

  twiState_e state, stNext;
  logic [2:0] bitCnt, cntNext;
  logic byteFull, fullNext;
  logic byteIdx, idxNext;
  logic commitPend, pendNext;
  logic mAck;
  logic addrHit;

  assign addrHit = (rxByte[BYTE_W-1:1] == {ADDR_HI, strapSel});

  always_comb begin
    strb     = '0;
    stNext   = state;
    cntNext  = bitCnt;
    fullNext = byteFull;
    idxNext  = byteIdx;
    pendNext = commitPend;
    if (stopEvt) begin
      stNext          = S_IDLE;
      pendNext        = 1'b0;
      strb.drvRelease = 1'b1;
    end else if (startEvt) begin
      stNext          = S_ADDR;
      cntNext         = '0;
      fullNext        = 1'b0;
      pendNext        = 1'b0;
      strb.drvRelease = 1'b1;
    end else begin
      case (state)
        S_ADDR, S_PTR, S_WDATA: begin
          if (sclRise && !byteFull) begin
            strb.shiftIn = 1'b1;
            cntNext      = 3'(bitCnt + 3'd1);
            if (bitCnt == 3'd7) fullNext = 1'b1;
          end else if (sclFall && byteFull) begin
            fullNext = 1'b0;
            cntNext  = '0;
            if (state == S_ADDR) begin
              if (addrHit) begin
                strb.drvAck = 1'b1;
                stNext      = S_ADDR_ACK;
              end else begin
                stNext = S_IGNORE;
              end
            end else if (state == S_PTR) begin
              strb.ptrLoad = 1'b1;
              strb.drvAck  = 1'b1;
              idxNext      = 1'b0;
              stNext       = S_RX_ACK;
            end else begin
              strb.drvAck = 1'b1;
              stNext      = S_RX_ACK;
              if (!byteIdx) begin
                strb.msbLoad = 1'b1;
                idxNext      = 1'b1;
              end else begin
                pendNext = 1'b1;
                idxNext  = 1'b0;
              end
            end
          end
        end
        S_ADDR_ACK: if (sclFall) begin
          if (rxByte[0]) begin
            strb.captureRd = 1'b1;
            idxNext        = 1'b0;
            cntNext        = '0;
            stNext         = S_TX;
          end else begin
            strb.drvRelease = 1'b1;
            stNext          = S_PTR;
          end
        end
        S_RX_ACK: if (sclFall) begin
          strb.drvRelease = 1'b1;
          stNext          = S_WDATA;
          if (commitPend) begin
            strb.commit = 1'b1;
            pendNext    = 1'b0;
          end
        end
        S_TX: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            strb.drvRelease = 1'b1;
            cntNext         = '0;
            stNext          = S_MACK;
          end else begin
            strb.txShift = 1'b1;
            cntNext      = 3'(bitCnt + 3'd1);
          end
        end
        S_MACK: if (sclFall) begin
          if (!mAck) begin
            stNext = S_IGNORE;
          end else if (!byteIdx) begin
            strb.txLoadLsb = 1'b1;
            idxNext        = 1'b1;
            stNext         = S_TX;
          end else begin
            strb.txLoadMsb = 1'b1;
            idxNext        = 1'b0;
            stNext         = S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      bitCnt     <= '0;
      byteFull   <= 1'b0;
      byteIdx    <= 1'b0;
      commitPend <= 1'b0;
      mAck       <= 1'b0;
    end else begin
      state      <= stNext;
      bitCnt     <= cntNext;
      byteFull   <= fullNext;
      byteIdx    <= idxNext;
      commitPend <= pendNext;
      if (state == S_MACK && sclRise) mAck <= !sdaBit;
    end
  end

  // A data pair is only committed after its low byte was acknowledged.
  p_commit_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> commitPend && $past(state == S_RX_ACK));

endmodule

// File: rtl/twi_ptr_slave.sv
module twi_ptr_slave
  import twi_ptr_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapSel,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [WORD_W-1:0] regWrData,
  input  logic [WORD_W-1:0] regRdData
);

  twiStrobe_t strb;
  logic startEvt, stopEvt, sclRise, sclFall, sdaBit;
  logic [BYTE_W-1:0] rxByte;

  twi_ptr_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startEvt (startEvt),
    .stopEvt  (stopEvt),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .sdaBit   (sdaBit),
    .rxByte   (rxByte),
    .strapSel (strapSel),
    .strb     (strb)
  );

  twi_ptr_datapath #(
    .PTR_W       (PTR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strb      (strb),
    .regRdData (regRdData),
    .startEvt  (startEvt),
    .stopEvt   (stopEvt),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .sdaBit    (sdaBit),
    .rxByte    (rxByte),
    .sdaOe     (sdaOe),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData)
  );

  // Once the slave has dropped out of a transfer it stays silent.
  p_ignore_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (u_ctrl.state == S_IGNORE) && $past(u_ctrl.state == S_IGNORE) |-> !sdaOe && !regWrEn);

endmodule

// File: tb/sim_twi_ptr_slave.sv
`timescale 1ns/1ps
module sim_twi_ptr_slave;

  localparam int PW = 2;
  localparam int NREG = 1 << PW;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] strapSel = 2'd0;
  logic sdaOe, regWrEn;
  logic [PW-1:0] regAddr;
  logic [15:0] regWrData, regRdData;
  logic sdaLine;

  logic [15:0] bank [NREG];
  logic [15:0] expBank [NREG];
  int wrCount = 0;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;
  assign regRdData = bank[regAddr];

  twi_ptr_slave #(.PTR_W(PW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .strapSel(strapSel),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [15:0] initVal(int i);
    return 16'hC3A0 ^ 16'(i * 16'h1111);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) bank[i] <= initVal(i);
    end else if (regWrEn) begin
      bank[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitClk(H/2);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(H/2);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitClk(H/2);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b; waitClk(H/2);
    sclM = 1'b1; waitClk(H/2);
    seen = sdaLine; waitClk(H/2);
    sclM = 1'b0; waitClk(H/2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(!masterAck, s);
  endtask

  task automatic setPtr(input logic [7:0] addrW, input logic [7:0] p);
    bit a;
    busStart; sendByte(addrW, a); sendByte(p, a); busStop;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b0, b1, b2, b3;
    int w0;
    logic [7:0] me;
    for (int i = 0; i < NREG; i++) expBank[i] = initVal(i);
    waitClk(6);
    rstN = 1'b1;
    waitClk(4);

    // reset state
    check(regAddr == 0, "R3 reset pointer", regAddr, 0);
    check(sdaOe == 1'b0, "R7 reset line released", sdaOe, 0);
    check(regWrEn == 1'b0, "R4 reset no write", regWrEn, 0);

    // R1 / R6: address decode sweep across strap codes
    for (int s = 0; s < 4; s++) begin
      strapSel = 2'(s);
      for (int a = 0; a < 128; a++) begin
        if (s != 0 && (a < 8'h48 || a > 8'h4F)) continue;
        busStart; sendByte({7'(a), 1'b0}, ack); busStop;
        check(ack == (a == (8'h48 + s)), $sformatf("R1 addr %0h strap %0d", a, s), ack, a == (8'h48 + s));
      end
    end
    check(wrCount == 0, "R5 address-only writes nothing", wrCount, 0);
    check(regAddr == 0, "R3 pointer untouched by address sweep", regAddr, 0);

    // R7: foreign address, then bytes that would otherwise be a write
    strapSel = 2'd0;
    busStart;
    sendByte({7'h49, 1'b0}, ack); check(!ack, "R7 foreign addr nack", ack, 0);
    sendByte(8'h01, ack); check(!ack, "R7 foreign ptr nack", ack, 0);
    sendByte(8'h5A, ack); check(!ack, "R7 foreign data nack", ack, 0);
    sendByte(8'hA5, ack); check(!ack, "R7 foreign data nack", ack, 0);
    busStop; waitClk(4);
    check(regAddr == 0 && wrCount == 0, "R7 no pointer or write", {regAddr, 16'(wrCount)}, 0);

    // R3 / R4 / R6: write every pointer value 0..7 (low PW bits select)
    strapSel = 2'd2;
    me = {7'h4A, 1'b0};
    for (int p = 0; p < 8; p++) begin
      logic [15:0] d;
      d = 16'h1357 ^ 16'(p * 16'h2468);
      w0 = wrCount;
      busStart;
      sendByte(me, ack);      check(ack, "R6 addr ack", ack, 1);
      sendByte(8'(p), ack);   check(ack, "R6 ptr ack", ack, 1);
      sendByte(d[15:8], ack); check(ack, "R6 msb ack", ack, 1);
      sendByte(d[7:0], ack);  check(ack, "R6 lsb ack", ack, 1);
      busStop; waitClk(4);
      expBank[p % NREG] = d;
      check(regAddr == PW'(p), "R3 pointer value", regAddr, p % NREG);
      check(bank[p % NREG] == d, "R4 written word", bank[p % NREG], d);
      check(wrCount == w0 + 1, "R4 one write per pair", wrCount - w0, 1);
    end

    // R4: two pairs in one transfer hit the same register twice
    w0 = wrCount;
    busStart; sendByte(me, ack); sendByte(8'h01, ack);
    sendByte(8'h11, ack); sendByte(8'h22, ack);
    sendByte(8'h33, ack); sendByte(8'h44, ack);
    busStop; waitClk(4);
    expBank[1] = 16'h3344;
    check(wrCount == w0 + 2, "R4 two pairs two writes", wrCount - w0, 2);
    check(bank[1] == 16'h3344, "R4 last pair wins", bank[1], 16'h3344);

    // R4: lone high byte is dropped
    w0 = wrCount;
    busStart; sendByte(me, ack); sendByte(8'h02, ack); sendByte(8'hEE, ack); busStop; waitClk(4);
    check(wrCount == w0 && bank[2] == expBank[2], "R4 lone byte not written", bank[2], expBank[2]);

    // R5: pointer-only write
    w0 = wrCount;
    setPtr(me, 8'h03); waitClk(4);
    check(regAddr == 2'd3, "R5 pointer-only sets pointer", regAddr, 3);
    check(wrCount == w0, "R5 pointer-only no write", wrCount - w0, 0);

    // R8 / R9: reads per register, twice without re-sending pointer
    for (int p = 0; p < NREG; p++) begin
      setPtr(me, 8'(p));
      for (int rep = 0; rep < 2; rep++) begin
        busStart;
        sendByte(me | 8'h01, ack); check(ack, "R6 read addr ack", ack, 1);
        recvByte(1'b1, b0); recvByte(1'b0, b1);
        busStop;
        check({b0, b1} == expBank[p], $sformatf("R8 read reg %0d pass %0d", p, rep), {b0, b1}, expBank[p]);
      end
    end

    // R9: read beyond the low byte repeats the pair
    setPtr(me, 8'h01);
    busStart; sendByte(me | 8'h01, ack);
    recvByte(1'b1, b0); recvByte(1'b1, b1); recvByte(1'b1, b2); recvByte(1'b0, b3);
    busStop;
    check({b0, b1} == expBank[1], "R9 msb then lsb", {b0, b1}, expBank[1]);
    check({b2, b3} == expBank[1], "R9 repeated pair", {b2, b3}, expBank[1]);

    // R10: NACK after the high byte, slave must stay off the line
    busStart; sendByte(me | 8'h01, ack);
    recvByte(1'b0, b0); recvByte(1'b0, b1);
    busStop;
    check(b0 == expBank[1][15:8], "R10 msb before nack", b0, expBank[1][15:8]);
    check(b1 == 8'hFF, "R10 released after nack", b1, 8'hFF);

    // R11: repeated start in mid-write aborts, pointer taken, no write
    w0 = wrCount;
    busStart; sendByte(me, ack); sendByte(8'h00, ack); sendByte(8'h99, ack);
    busStart; sendByte(me | 8'h01, ack);
    check(ack, "R11 addr after repeated start", ack, 1);
    recvByte(1'b1, b0); recvByte(1'b0, b1);
    busStop; waitClk(4);
    check(wrCount == w0, "R11 partial pair dropped", wrCount - w0, 0);
    check({b0, b1} == expBank[0], "R11 read after restart", {b0, b1}, expBank[0]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule